// File: doc/BRIEF.md
# Synchronous Burst SRAM Command Decoder

This block turns the clock-sampled control pins of a single-ported synchronous burst SRAM into internal operations: starting a read or a write, continuing a burst, holding a burst in place, and deselecting. It also merges the write controls into per-byte-lane write enables for a word-wide storage array that sits inside the block. It is meant to sit behind a pin-level model or a bus bridge that presents SRAM-style strobes. The bench then watches which access each clock edge produced, at which address, and with which byte lanes.

There are two address strobes. The processor-side strobe is gated by the primary chip enable and always begins a read. The controller-side strobe can begin either a read or a write. The two secondary chip enables are only looked at when a strobe is present. Between strobes, an advance input steps a small wrapping counter through the low address bits, and each step performs a read or a write according to the write controls of that cycle. When neither a strobe nor advance is present, the burst is held and no access takes place.

Top module: `sbsram_ctrl`

## Requirements
- R1: Every control, address and data input is sampled on the rising clock edge, and the outputs are registers that show the decision of that edge from just after it. A synchronous active-high reset clears `lane_we`, `rd_req`, `desel` and `acc_addr` to zero and leaves no burst active.
- R2: While `cs_pri_n` is high, a low `strb_cpu_n` starts nothing. With `strb_ctl_n` high it produces no access and no deselect, and an active burst may still advance in that cycle.
- R3: `cs_hi` and `cs_lo_n` are only evaluated in a cycle with an accepted strobe. During a burst advance they have no effect, even at their inactive levels.
- R4: A low `wr_all_n` in a write access drives all `LANES` bits of `lane_we` high, whatever `wr_byte_n` and `lane_n` are.
- R5: With `wr_all_n` high, a write needs `wr_byte_n` low and at least one low bit in `lane_n`. Bit i of `lane_we` equals the inverse of `lane_n[i]`, with lane i holding data bits [8i+7:8i], and any lane combination is allowed. When `lane_n` is all ones, or when `wr_byte_n` is high, the access is a read.
- R6: A strobe accepted while any chip enable is at its inactive level gives `desel`=1 for one cycle with no access, and it ends the burst. A later advance then performs no access.
- R7: An accepted `strb_ctl_n` with the processor strobe not accepted loads `addr` as the burst start and performs a write there if the write controls request one, and otherwise a read.
- R8: An advance (`adv_n` low, no accepted strobe, burst active) increments a 2-bit counter added to the low two bits of the start address, with wrap, keeping the upper bits. The accesses therefore run start, +1, +2, +3 within the aligned group of four and then return to start.
- R9: A cycle with no accepted strobe and `adv_n` high performs no access and keeps the burst address and count, so the next advance continues from where the burst stopped.
- R10: An accepted `strb_cpu_n` always starts a read at `addr` and ignores the write controls. It takes priority over `strb_ctl_n` in the same cycle.
- R11: After a read edge, `rdata` holds the stored word at the accessed address and keeps that value until the next read. `acc_addr` shows the address of the last access and is held when no access occurs.
- R12: All controls are active low except `cs_hi`, which is active high. A strobe accepted with `cs_hi` low, or with `cs_lo_n` high, deselects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_pri_n | input | 1 | Primary chip enable, active low; gates the processor strobe |
| cs_hi | input | 1 | Secondary chip enable, active high |
| cs_lo_n | input | 1 | Secondary chip enable, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| lane_we | output | LANES | Registered per-lane write enables of the last edge |
| rd_req | output | 1 | Registered read-access indication |
| desel | output | 1 | Registered deselect indication |
| acc_addr | output | ADDR_W | Address of the most recent access |
| rdata | output | LANES*LANE_W | Registered read data |

## Verification
The main decode is driven with controller-strobe writes under a global write and under several byte-lane masks. Comparing these shows that the global override ignores the masks and that the lane enables follow the inverted strobes. Empty masks and masks with the byte enable off are included to show that both fall back to reads. Processor-strobe starts carrying active write controls, alone and together with the controller strobe, distinguish the read-only start and its priority from a controller start. A four-beat write burst is followed by a read burst that is suspended and then advanced past the wrap point, which tells linear wrapping apart from carrying into the upper bits and shows that the burst state is held. Deselects are caused through each chip enable in turn, and masked processor strobes are given both while idle and in the middle of a burst, which separates a strobe that is blocked from one that deselects.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/sbsram_strobe_dec.sv
// Strobe acceptance and chip-enable qualification.
module sbsram_strobe_dec (
  input  logic cs_pri_n,
  input  logic cs_hi,
  input  logic cs_lo_n,
  input  logic strb_cpu_n,
  input  logic strb_ctl_n,
  output logic start,
  output logic start_cpu,
  output logic desel_now
);
  logic cpu_seen;
  logic ctl_seen;
  logic any_seen;
  logic enables_ok;

  always_comb begin
    // primary enable blocks the processor strobe outright
    cpu_seen   = !strb_cpu_n && !cs_pri_n;
    ctl_seen   = !strb_ctl_n;
    any_seen   = cpu_seen || ctl_seen;
    // secondary enables only matter when a strobe is seen
    enables_ok = !cs_pri_n && cs_hi && !cs_lo_n;
    start      = any_seen && enables_ok;
    start_cpu  = cpu_seen && enables_ok;
    desel_now  = any_seen && !enables_ok;
  end
endmodule

// File: rtl/sbsram_byte_mask.sv
// Merges the global write override with the per-lane byte strobes.
module sbsram_byte_mask #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] mask,
  output logic             wr_any
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask[l] = !wr_all_n || (!wr_byte_n && !lane_n[l]);
  end
  assign wr_any = |mask;
endmodule

// File: rtl/sbsram_burst_ctr.sv
// Burst start address and wrapping low-bit counter.
module sbsram_burst_ctr #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] eff_addr
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nxt;
  logic [BURST_W-1:0] cnt_use;
  logic [BURST_W-1:0] lo_sum;

  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
    cnt_use = step ? cnt_nxt : cnt_q;
    lo_sum  = base_q[BURST_W-1:0] + cnt_use;
    if (load) eff_addr = addr_in;
    else      eff_addr = {base_q[ADDR_W-1:BURST_W], lo_sum};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_nxt;
    end
  end

  // R9: without load or step the burst position is kept
  p_suspend_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(cnt_q) && $stable(base_q)));
  // R8: a step advances the counter by one, wrapping at its width
  p_step_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> (cnt_q == ($past(cnt_q) + 1'b1)));
  // R7: a load restarts the burst at the presented address
  p_load_start_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == '0 && base_q == $past(addr_in)));
endmodule

// File: rtl/sbsram_array.sv
// Byte-lane storage, one inferable memory per lane, registered read.
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)     rd_q <= '0;
      else if (re) rd_q <= mem[addr];
    end

    assign rdata[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sbsram_ctrl.sv
// Top: command decode, burst sequencing, lane write enables, storage.
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_pri_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  lane_we,
  output logic              rd_req,
  output logic              desel,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] rdata
);
  logic              start;
  logic              start_cpu;
  logic              desel_now;
  logic [LANES-1:0]  mask;
  logic              wr_any;
  logic              step;
  logic              active_q;
  logic [ADDR_W-1:0] eff_addr;
  acc_e              kind;
  logic [LANES-1:0]  arr_we;
  logic              arr_re;

  sbsram_strobe_dec u_dec (
    .cs_pri_n   (cs_pri_n),
    .cs_hi      (cs_hi),
    .cs_lo_n    (cs_lo_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .start      (start),
    .start_cpu  (start_cpu),
    .desel_now  (desel_now)
  );

  sbsram_byte_mask #(.LANES(LANES)) u_mask (
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_n    (lane_n),
    .mask      (mask),
    .wr_any    (wr_any)
  );

  // advance only continues a live burst when no strobe was accepted
  assign step = !start && !desel_now && !adv_n && active_q;

  sbsram_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .step     (step),
    .addr_in  (addr),
    .eff_addr (eff_addr)
  );

  always_comb begin
    kind = ACC_NONE;
    if (start) kind = (start_cpu || !wr_any) ? ACC_READ : ACC_WRITE;
    else if (step) kind = wr_any ? ACC_WRITE : ACC_READ;
    arr_we = (kind == ACC_WRITE) ? mask : '0;
    arr_re = (kind == ACC_READ);
  end

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk   (clk),
    .rst   (rst),
    .we    (arr_we),
    .re    (arr_re),
    .addr  (eff_addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_we  <= '0;
      rd_req   <= 1'b0;
      desel    <= 1'b0;
      acc_addr <= '0;
      active_q <= 1'b0;
    end else begin
      lane_we <= arr_we;
      rd_req  <= arr_re;
      desel   <= desel_now;
      if (kind != ACC_NONE) acc_addr <= eff_addr;
      if (desel_now)  active_q <= 1'b0;
      else if (start) active_q <= 1'b1;
    end
  end

  // R7: one edge never reports both a read and a write
  p_rd_we_excl_r7: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (lane_we == '0));
  // R6: a deselect edge carries no access
  p_desel_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    desel |-> (!rd_req && lane_we == '0));
  // R2: a blocked processor strobe while idle does nothing at all
  p_cpu_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (!strb_cpu_n && cs_pri_n && strb_ctl_n && !active_q)
      |=> (!rd_req && lane_we == '0 && !desel));
  // R10: a qualified processor strobe always yields a read
  p_cpu_read_r10: assert property (@(posedge clk) disable iff (rst)
    (!strb_cpu_n && !cs_pri_n && cs_hi && !cs_lo_n)
      |=> (rd_req && lane_we == '0));
  // R4: controller start with global write enables every lane
  p_gw_all_r4: assert property (@(posedge clk) disable iff (rst)
    (!strb_ctl_n && strb_cpu_n && !cs_pri_n && cs_hi && !cs_lo_n && !wr_all_n)
      |=> (lane_we == '1));
endmodule

// File: tb/sbsram_ctrl_bench.sv
module sbsram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cs_pri_n, cs_hi, cs_lo_n;
  logic              strb_cpu_n, strb_ctl_n, adv_n;
  logic              wr_all_n, wr_byte_n;
  logic [LANES-1:0]  lane_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [LANES-1:0]  lane_we;
  logic              rd_req, desel;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] rdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbsram_ctrl u_sbsram_ctrl (
    .clk(clk), .rst(rst), .cs_pri_n(cs_pri_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .addr(addr), .wdata(wdata), .lane_we(lane_we), .rd_req(rd_req),
    .desel(desel), .acc_addr(acc_addr), .rdata(rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // operation outputs in one check: {desel, rd_req, lane_we}
  function automatic logic [31:0] ops();
    return {26'd0, desel, rd_req, lane_we};
  endfunction

  task automatic idle();
    cs_pri_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_n = 4'hF;
    addr = '0; wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] wv(input int i);
    return 32'hC0DE_0000 + i;
  endfunction

  task automatic t_reset();
    idle();
    rst = 1'b1;
    repeat (3) tick();
    chk("R1", "ops in reset", ops(), 32'h0);
    chk("R1", "acc_addr in reset", 32'(acc_addr), 32'h0);
    rst = 1'b0;
    tick();
    chk("R1", "ops after reset idle", ops(), 32'h0);
  endtask

  task automatic t_global_write();
    idle(); strb_ctl_n = 1'b0; addr = 6'd8; wr_all_n = 1'b0;
    wr_byte_n = 1'b0; lane_n = 4'b1010; wdata = 32'hAABB_CCDD;
    tick();
    chk("R4", "global write lanes", ops(), 32'h0F);
    chk("R7", "write address", 32'(acc_addr), 32'd8);
    idle(); tick();
    chk("R9", "idle cycle no access", ops(), 32'h0);
    idle(); strb_cpu_n = 1'b0; addr = 6'd8; tick();
    chk("R11", "read back global write", rdata, 32'hAABB_CCDD);
    chk("R10", "cpu start ops", ops(), 32'h10);
  endtask

  task automatic t_byte_write();
    idle(); strb_ctl_n = 1'b0; addr = 6'd12; wr_all_n = 1'b0; wdata = '0;
    tick();
    idle(); strb_ctl_n = 1'b0; addr = 6'd12; wr_byte_n = 1'b0;
    lane_n = 4'b0110; wdata = 32'h1122_3344;
    tick();
    chk("R5", "byte lanes 3 and 0", ops(), 32'h09);
    idle(); strb_ctl_n = 1'b0; addr = 6'd12; wr_byte_n = 1'b0; lane_n = 4'hF;
    wdata = 32'hFFFF_FFFF;
    tick();
    chk("R5", "empty mask reads", ops(), 32'h10);
    chk("R5", "merged byte data", rdata, 32'h1100_0044);
    idle(); strb_ctl_n = 1'b0; addr = 6'd12; wr_byte_n = 1'b1; lane_n = 4'h0;
    wdata = 32'hFFFF_FFFF;
    tick();
    chk("R5", "strobes without byte enable read", ops(), 32'h10);
    chk("R5", "data untouched", rdata, 32'h1100_0044);
  endtask

  task automatic t_cpu_read_only();
    idle(); strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; addr = 6'd8;
    wr_all_n = 1'b0; wr_byte_n = 1'b0; lane_n = 4'h0; wdata = '0;
    tick();
    chk("R10", "cpu start ignores write controls", ops(), 32'h10);
    chk("R10", "cpu start data", rdata, 32'hAABB_CCDD);
    idle(); strb_ctl_n = 1'b0; addr = 6'd8; tick();
    chk("R10", "word not overwritten", rdata, 32'hAABB_CCDD);
  endtask

  task automatic t_burst();
    idle(); strb_ctl_n = 1'b0; addr = 6'd20; wr_all_n = 1'b0; wdata = wv(0);
    tick();
    chk("R7", "burst write start", 32'(acc_addr), 32'd20);
    for (int i = 1; i < 4; i++) begin
      idle(); adv_n = 1'b0; wr_all_n = 1'b0; wdata = wv(i); tick();
      chk("R8", "write burst beat addr", 32'(acc_addr), 32'(20 + i));
      chk("R8", "write burst beat lanes", ops(), 32'h0F);
    end
    idle(); strb_ctl_n = 1'b0; addr = 6'd22; tick();
    chk("R7", "read start data", rdata, wv(2));
    idle(); adv_n = 1'b0; cs_hi = 1'b0; cs_lo_n = 1'b1; tick();
    chk("R3", "advance ignores secondary enables", ops(), 32'h10);
    chk("R8", "beat +1 data", rdata, wv(3));
    idle(); tick();
    chk("R9", "suspend no access", ops(), 32'h0);
    chk("R11", "rdata held", rdata, wv(3));
    chk("R11", "acc_addr held", 32'(acc_addr), 32'd23);
    idle(); adv_n = 1'b0; tick();
    chk("R8", "wrap to group start", 32'(acc_addr), 32'd20);
    chk("R8", "wrapped data", rdata, wv(0));
    idle(); adv_n = 1'b0; tick();
    chk("R8", "after wrap addr", 32'(acc_addr), 32'd21);
    idle(); adv_n = 1'b0; wr_byte_n = 1'b0; lane_n = 4'b1110; wdata = 32'h0000_00EE;
    tick();
    chk("R8", "mid-burst byte write", ops(), 32'h01);
    chk("R8", "mid-burst write addr", 32'(acc_addr), 32'd22);
  endtask

  task automatic t_deselect();
    idle(); strb_ctl_n = 1'b0; cs_hi = 1'b0; addr = 6'd4; tick();
    chk("R12", "cs_hi low deselects", ops(), 32'h20);
    idle(); adv_n = 1'b0; tick();
    chk("R6", "advance after deselect", ops(), 32'h0);
    idle(); strb_ctl_n = 1'b0; cs_pri_n = 1'b1; tick();
    chk("R6", "primary off with ctl strobe", ops(), 32'h20);
    idle(); strb_cpu_n = 1'b0; cs_lo_n = 1'b1; tick();
    chk("R12", "cs_lo_n high deselects", ops(), 32'h20);
  endtask

  task automatic t_cpu_mask();
    idle(); strb_cpu_n = 1'b0; cs_pri_n = 1'b1; adv_n = 1'b0; tick();
    chk("R2", "blocked cpu strobe while idle", ops(), 32'h0);
    idle(); strb_cpu_n = 1'b0; addr = 6'd16; tick();
    chk("R10", "cpu burst start addr", 32'(acc_addr), 32'd16);
    idle(); strb_cpu_n = 1'b0; cs_pri_n = 1'b1; adv_n = 1'b0; addr = 6'd40; tick();
    chk("R2", "blocked strobe lets burst advance", ops(), 32'h10);
    chk("R2", "advance addr", 32'(acc_addr), 32'd17);
  endtask

  initial begin
    t_reset();
    t_global_write();
    t_byte_write();
    t_cpu_read_only();
    t_burst();
    t_deselect();
    t_cpu_mask();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule